// File: doc/BRIEF.md
# Video Bus-Steal Arbiter

This block runs from a fast system clock. It divides that clock down to produce the CPU phase clock, and it lends the shared memory bus to a video requester that runs in another clock domain. When the requester asks for the bus, the block waits for a fixed decision point late in the phase-clock period. It then pulls the shared open-drain CPU ready line low for the last two ticks before the phase clock's falling edge. At that falling edge it drops the bus-enable output, so the CPU floats its bus, and it raises the grant.

When the requester reports that it is done, the block makes a short push-high on the ready line. This helps the external pull-up bring the line back up before the next falling edge. The block then stops driving the line, and at the falling edge it restores bus enable and removes the grant. If the ready line is already low when the block is about to pull it, the block takes this as a CPU that is waiting for an interrupt. In that case it never drives the line high, and on release it only stops pulling low.

The ready pin is presented as an output-enable and an output-value pair, plus a sampled input. The pad and the pull-up are outside the block.

Top module: `vid_bus_steal`

## Requirements
- R1: The phase clock `phi2` is low for 7 system ticks and then high for 7 ticks, for a 14-tick period. The phase counter starts at 0 out of reset, with `phi2` low. The falling edge of `phi2` is the wrap from count 13 to count 0.
- R2: A request is acted on only if its synchronized value is high at count 9, which is 4 ticks before a falling edge. Synchronization adds a 2-tick delay. A request that misses count 9 waits for count 9 of the next period.
- R3: After an accepted request, the block pulls the ready line low (`rdy_oe`=1, `rdy_out`=0) at counts 12 and 13. At the following count 0, `bus_en` goes low and `vid_grant` goes high.
- R4: While the grant is held and no release is under way, the ready line is pulled low and `phi2` keeps its normal period.
- R5: When the synchronized done input is high at count 9 while the grant is held, the block drives the ready line high (`rdy_oe`=1, `rdy_out`=1) at counts 10 and 11. It does not drive the line at counts 12 and 13.
- R6: At the count-0 falling edge that ends the release, `bus_en` returns high and `vid_grant` returns low in the same tick. `bus_en` changes only at count 0.
- R7: If `rdy_in` is low at count 11, the last tick before the block pulls the line, the block still pulls the line low during the grant. At counts 10 to 13 of the release, however, it leaves `rdy_oe` at 0 and never drives the line high.
- R8: While reset is active, `rdy_oe` is 0, `bus_en` is 1, `vid_grant` is 0 and `phi2` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_req | input | 1 | Video bus request, asynchronous level |
| vid_done | input | 1 | Video access finished, asynchronous level |
| vid_grant | output | 1 | Bus is lent to the video requester |
| phi2 | output | 1 | CPU phase clock |
| bus_en | output | 1 | CPU bus enable, low floats the CPU bus |
| rdy_oe | output | 1 | Ready pin output enable |
| rdy_out | output | 1 | Ready pin value when enabled |
| rdy_in | input | 1 | Sampled level of the shared ready line |

## Verification
The bench sweeps every request arrival phase against every done arrival phase, once with a free ready line and once with the CPU holding it low. This covers requests that land just before and just after the count-9 decision point. A design with the synchronizer latency miscounted would grant one period early or late. A design with an off-by-one pull window would drop the bus enable before the ready line had been low for two ticks. When the CPU holds the ready line low, the bench checks that the enable stays off through the whole release. A design that ignored the sampled level would fight the CPU's own pull-down during the push-high ticks.

// File: rtl/vid_bus_steal.sv
module vid_bus_steal #(
  parameter int LO_TICKS  = 7,
  parameter int HI_TICKS  = 7,
  parameter int PULL_LEAD = 2,
  parameter int KICK_LEAD = 4,
  parameter int KICK_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vid_req,
  input  logic vid_done,
  output logic vid_grant,
  output logic phi2,
  output logic bus_en,
  output logic rdy_oe,
  output logic rdy_out,
  input  logic rdy_in
);
  localparam int PERIOD = LO_TICKS + HI_TICKS;
  localparam int CW     = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST     = CW'(PERIOD - 1);
  localparam logic [CW-1:0] DECIDE   = CW'(PERIOD - KICK_LEAD - 1);
  localparam logic [CW-1:0] PULL_AT  = CW'(PERIOD - PULL_LEAD);
  localparam logic [CW-1:0] SAMPLE   = CW'(PERIOD - PULL_LEAD - 1);
  localparam logic [CW-1:0] KICK_END = CW'(PERIOD - KICK_LEAD + KICK_LEN - 1);
  localparam logic [CW-1:0] HI_START = CW'(LO_TICKS);

  typedef enum logic [2:0] {IDLE, ASSERT_RDY, GRANTED, KICK_HIGH, RELEASE} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [1:0]    req_q, done_q;
  logic          cpu_hold;

  wire req_s  = req_q[1];
  wire done_s = done_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      req_q  <= '0;
      done_q <= '0;
    end else begin
      cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
      req_q  <= {req_q[0], vid_req};
      done_q <= {done_q[0], vid_done};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= IDLE;
      cpu_hold <= 1'b0;
    end else begin
      case (state)
        IDLE:       if (req_s && cnt == DECIDE) state <= ASSERT_RDY;
        ASSERT_RDY: begin
          if (cnt == SAMPLE) cpu_hold <= !rdy_in;
          if (cnt == LAST) state <= GRANTED;
        end
        GRANTED:    if (done_s && cnt == DECIDE) state <= KICK_HIGH;
        KICK_HIGH:  if (cnt == KICK_END) state <= RELEASE;
        RELEASE:    if (cnt == LAST) state <= IDLE;
        default:    state <= IDLE;
      endcase
    end

  assign phi2      = cnt >= HI_START;
  assign vid_grant = state == GRANTED || state == KICK_HIGH || state == RELEASE;
  assign bus_en    = !vid_grant;
  assign rdy_oe    = (state == ASSERT_RDY && cnt >= PULL_AT) || state == GRANTED ||
                     (state == KICK_HIGH && !cpu_hold);
  assign rdy_out   = state == KICK_HIGH;
endmodule

module vid_bus_steal_chk #(
  parameter int PERIOD    = 14,
  parameter int KICK_LEAD = 4,
  parameter int KICK_LEN  = 2,
  parameter int CW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          cpu_hold,
  input logic          phi2,
  input logic          bus_en,
  input logic          vid_grant,
  input logic          rdy_oe,
  input logic          rdy_out
);
  localparam logic [CW-1:0] KS = CW'(PERIOD - KICK_LEAD);
  localparam logic [CW-1:0] KE = CW'(PERIOD - KICK_LEAD + KICK_LEN);

  // R1
  phi2_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |-> cnt == '0);

  // R3
  be_after_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_en) |-> $past(rdy_oe && !rdy_out));

  // R4
  grant_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_grant && cnt < KS) |-> (rdy_oe && !rdy_out));

  // R5
  kick_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_oe && rdy_out) |-> (cnt >= KS && cnt < KE));

  // R6
  be_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_en) |-> cnt == '0);

  // R7
  no_kick_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && vid_grant) |-> !(rdy_oe && rdy_out));

  // R8
  always @(posedge clk)
    if (!rst_n) reset_idle_chk: assert (bus_en && !rdy_oe && !vid_grant && !phi2);
endmodule

bind vid_bus_steal vid_bus_steal_chk #(
  .PERIOD(PERIOD), .KICK_LEAD(KICK_LEAD), .KICK_LEN(KICK_LEN), .CW(CW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cpu_hold(cpu_hold), .phi2(phi2),
  .bus_en(bus_en), .vid_grant(vid_grant), .rdy_oe(rdy_oe), .rdy_out(rdy_out)
);

// File: tb/test_vid_bus_steal.sv
module test_vid_bus_steal;
  localparam int CLK_PERIOD = 10;
  localparam int P = 14;

  logic clk = 0, rst_n = 0;
  logic vid_req = 0, vid_done = 0, cpu_wai = 0;
  logic vid_grant, phi2, bus_en, rdy_oe, rdy_out, rdy_in;
  int   tcount = 0, n_run = 0, n_fail = 0;

  assign rdy_in = cpu_wai ? 1'b0 : (rdy_oe ? rdy_out : 1'b1);

  vid_bus_steal i_vid_bus_steal (
    .clk(clk), .rst_n(rst_n), .vid_req(vid_req), .vid_done(vid_done),
    .vid_grant(vid_grant), .phi2(phi2), .bus_en(bus_en),
    .rdy_oe(rdy_oe), .rdy_out(rdy_out), .rdy_in(rdy_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) tcount <= tcount + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at tick %0d: actual %0d expected %0d", req, tcount, act, exp);
    end
  endtask

  task automatic run_txn(input int aoff, input int boff, input bit wai);
    int a, b, d, e;
    string tag;
    bit eg, eo;
    cpu_wai = wai;
    while (tcount % P != aoff) @(negedge clk);
    a = tcount;
    vid_req = 1;
    d = a + 2;
    while (d % P != 9) d++;
    b = d + 5 + boff;
    e = b + 2;
    while (e % P != 9) e++;
    for (int t = a; t <= e + 5; t++) begin
      if (t != a) @(negedge clk);
      if (t == b) vid_done = 1;
      eg = (t >= d + 5) && (t <= e + 4);
      eo = (t >= d + 3 && t <= e) || (t >= e + 1 && t <= e + 2 && !wai);
      if (t < d + 3) tag = "R2";
      else if (t <= d + 5) tag = "R3";
      else if (t <= e) tag = "R4";
      else if (t <= e + 4) tag = wai ? "R7" : "R5";
      else tag = "R6";
      // R1 phase clock shape
      check(phi2 == ((t % P) >= 7), "R1", phi2, (t % P) >= 7);
      check(vid_grant == eg, {tag, " grant"}, vid_grant, eg);
      check(bus_en == !eg, {tag, " bus_en"}, bus_en, !eg);
      check(rdy_oe == eo, {tag, " rdy_oe"}, rdy_oe, eo);
      if (eo) check(rdy_out == (t >= e + 1 && t <= e + 2), {tag, " rdy_out"},
                    rdy_out, (t >= e + 1 && t <= e + 2));
    end
    vid_req = 0;
    vid_done = 0;
    cpu_wai = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(rdy_oe == 0, "R8 rdy_oe", rdy_oe, 0);
    check(bus_en == 1, "R8 bus_en", bus_en, 1);
    check(vid_grant == 0, "R8 grant", vid_grant, 0);
    check(phi2 == 0, "R8 phi2", phi2, 0);
    rst_n = 1;
    @(negedge clk);
    for (int w = 0; w < 2; w++)
      for (int ao = 0; ao < P; ao++)
        for (int bo = 0; bo < P; bo++)
          run_txn(ao, bo, w[0]);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule